// File: doc/BRIEF.md
# Local Memory Cycle Strobe Generator

This block sequences the control strobes of a 16-bit local memory bus that carries DRAM, a boot ROM and a small identification ROM. A fast input clock is divided into memory cycles of sixteen ticks. At the last tick of every cycle the block decides what the next cycle will be: a DRAM refresh, a memory access, or nothing. It then drives the row strobe, the DRAM output enable, the write strobe, a refresh indicator, and a shared line. In the row phase of an access cycle that line is the ROM chip select, and after the row phase it carries address bit 13.

A requester presents an access by holding `req_valid` with its address, direction, identification-ROM flag and the current boot-mode bit. The requester keeps these values until `acc_start` is seen. A refresh requester holds `refresh_req` in the same way until `refresh_act` rises. When both are pending at the same boundary, the refresh is served first. The block also produces a bus reset for external glue logic and a clock divided by eight.

Top module: `memstrobe_gen`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `oe_n`, `we_n` and `romsel_n` are high, and `refresh_act`, `acc_start`, `clk_div` and `busrst_n` are low. The internal reset is released on the second rising clock edge after `rst_n` goes high.
- R2: Once running, a memory cycle is 16 clock ticks (ticks 0 to 15). The request inputs are sampled only at the edge that ends tick 15. An access cycle raises `acc_start` for tick 0 only. A cycle with no request leaves every strobe inactive.
- R3: `ras_n` is low during ticks 0 to 4 of access and refresh cycles, and high at all other times.
- R4: A refresh request wins over a pending access at the same boundary. `refresh_act` is high for all 16 ticks of a refresh cycle and low otherwise. During a refresh cycle, `oe_n`, `we_n` and `romsel_n` stay high.
- R5: During ticks 0 to 4 of an access cycle, `romsel_n` is low only when all of these hold: the access is a read, boot mode is 0, and the address lies in 0x000010 to 0x00FFFF or in 0x1F0000 to 0x1FFFFF.
- R6: During ticks 0 to 4, `romsel_n` stays high for writes, for addresses outside both windows (for example 0x00000F and 0x010000), and for every access when boot mode is 1.
- R7: During ticks 5 to 15 of an access cycle, `romsel_n` equals bit 13 of the sampled address. In idle cycles it is high.
- R8: `oe_n` is low during ticks 5 to 15 of DRAM reads only. A DRAM read is a read that selects neither the ROM (as in R5) nor the identification ROM (`req_idrom`=1).
- R9: `we_n` is low during ticks 5 to 14 of write cycles only.
- R10: `busrst_n` goes low at once when `ext_reset_n` is low, and on the next edge when `soft_reset` is high. It returns high on the second rising edge after both are released.
- R11: With `div_sel` high, `clk_div` repeats four ticks high and four ticks low. With `div_sel` low, from the next edge on `clk_div` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request pending |
| req_addr | input | 21 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idrom | input | 1 | Access targets the identification ROM |
| boot_ram | input | 1 | Boot mode: 1 = code in RAM, ROM select disabled |
| refresh_req | input | 1 | DRAM refresh request pending |
| soft_reset | input | 1 | Software bus-reset request |
| ext_reset_n | input | 1 | External active-low reset input |
| div_sel | input | 1 | 1 = divide-by-8 clock output, 0 = reserved (held low) |
| ras_n | output | 1 | Row address strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| refresh_act | output | 1 | Refresh cycle in progress |
| romsel_n | output | 1 | ROM select in row phase, address bit 13 afterwards |
| acc_start | output | 1 | First tick of an accepted access cycle |
| busrst_n | output | 1 | Bus reset for external logic, active low |
| clk_div | output | 1 | Divided clock output |

## Verification
A refresh request and an access request can arrive at the same cycle boundary. The bench provokes this by raising both lines together and holding each until its own acknowledge appears. The reference model expects a full refresh cycle with quiet output enable, write strobe and ROM select, followed by the access in the next cycle. Both the model and the bench check that the access is neither lost nor merged into the refresh cycle. Bus reset and divider-select changes are also applied while accesses are running, so the bench shows they do not disturb the strobe sequence.

// File: rtl/memstrobe_pkg.sv
package memstrobe_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_REFR = 2'd1,
    CYC_ACC  = 2'd2
  } cyc_kind_e;

  // Context captured at a cycle boundary, held for the whole cycle
  typedef struct packed {
    cyc_kind_e kind;
    logic      wr;
    logic      a13;
    logic      rom_cs;
    logic      dram_rd;
  } cyc_ctx_t;

endpackage

// File: rtl/ms_rst_sync.sv
module ms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sclr,
  output logic rst_n_o
);

  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_nxt;

  always_comb begin
    q_nxt[0] = ~sclr;
    for (int i = 1; i < STAGES; i++) begin
      q_nxt[i] = q_q[i-1] & ~sclr;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q_q <= '0;
    end else begin
      q_q <= q_nxt;
    end
  end

  assign rst_n_o = q_q[STAGES-1];

endmodule

// File: rtl/ms_phase_seq.sv
module ms_phase_seq
  import memstrobe_pkg::*;
#(
  parameter int              PHASES  = 16,
  parameter int              PH_W    = $clog2(PHASES),
  parameter int              ADDR_W  = 21,
  parameter int              SEL_BIT = 13,
  parameter logic [ADDR_W-1:0] WIN0_LO = 'h000010,
  parameter logic [ADDR_W-1:0] WIN0_HI = 'h00FFFF,
  parameter logic [ADDR_W-1:0] WIN1_LO = 'h1F0000,
  parameter logic [ADDR_W-1:0] WIN1_HI = 'h1FFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_idrom,
  input  logic              boot_ram,
  input  logic              refresh_req,
  output logic [PH_W-1:0]   ph_nxt,
  output cyc_ctx_t          ctx_nxt
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;
  cyc_ctx_t        ctx_q;
  logic            boundary;
  logic            win_hit;
  logic            cs_hit;

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return ({1'b0, a} >= {1'b0, lo}) && ({1'b0, a} <= {1'b0, hi});
  endfunction

  assign boundary = (ph_q == PH_LAST);
  assign win_hit  = in_win(req_addr, WIN0_LO, WIN0_HI) |
                    in_win(req_addr, WIN1_LO, WIN1_HI);
  assign cs_hit   = ~req_write & ~boot_ram & win_hit;

  always_comb begin
    ph_nxt = boundary ? '0 : ph_q + PH_W'(1);
  end

  always_comb begin
    ctx_nxt = ctx_q;
    if (boundary) begin
      ctx_nxt = '{kind: CYC_IDLE, default: 1'b0};
      if (refresh_req) begin
        ctx_nxt.kind = CYC_REFR;
      end else if (req_valid) begin
        ctx_nxt.kind    = CYC_ACC;
        ctx_nxt.wr      = req_write;
        ctx_nxt.a13     = req_addr[SEL_BIT];
        ctx_nxt.rom_cs  = cs_hit;
        ctx_nxt.dram_rd = ~req_write & ~cs_hit & ~req_idrom;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      ctx_q <= '{kind: CYC_IDLE, default: 1'b0};
    end else begin
      ph_q  <= ph_nxt;
      ctx_q <= ctx_nxt;
    end
  end

endmodule

// File: rtl/ms_strobe_dec.sv
module ms_strobe_dec
  import memstrobe_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int PH_W      = $clog2(PHASES),
  parameter int ROW_TICKS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_nxt,
  input  cyc_ctx_t        ctx_nxt,
  output logic            ras_n,
  output logic            oe_n,
  output logic            we_n,
  output logic            refresh_act,
  output logic            romsel_n,
  output logic            acc_start
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] ROW_END = PH_W'(ROW_TICKS);

  logic row_ph, is_acc, is_ref;
  logic ras_d, oe_d, we_d, ref_d, rom_d, start_d;

  always_comb begin
    row_ph  = (ph_nxt < ROW_END);
    is_acc  = (ctx_nxt.kind == CYC_ACC);
    is_ref  = (ctx_nxt.kind == CYC_REFR);
    ras_d   = ~((is_acc | is_ref) & row_ph);
    oe_d    = ~(is_acc & ctx_nxt.dram_rd & ~row_ph);
    we_d    = ~(is_acc & ctx_nxt.wr & ~row_ph & (ph_nxt != PH_LAST));
    ref_d   = is_ref;
    start_d = is_acc & (ph_nxt == '0);
    if (is_acc) begin
      rom_d = row_ph ? ~ctx_nxt.rom_cs : ctx_nxt.a13;
    end else begin
      rom_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n       <= 1'b1;
      oe_n        <= 1'b1;
      we_n        <= 1'b1;
      refresh_act <= 1'b0;
      romsel_n    <= 1'b1;
      acc_start   <= 1'b0;
    end else begin
      ras_n       <= ras_d;
      oe_n        <= oe_d;
      we_n        <= we_d;
      refresh_act <= ref_d;
      romsel_n    <= rom_d;
      acc_start   <= start_d;
    end
  end

endmodule

// File: rtl/ms_clk_div.sv
module ms_clk_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel,
  output logic clk_div
);

  localparam int              CW   = $clog2(DIV);
  localparam logic [CW-1:0]   LAST = CW'(DIV - 1);
  localparam logic [CW-1:0]   HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          out_d;

  always_comb begin
    cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    out_d   = div_sel & (cnt_nxt >= HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clk_div <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      clk_div <= out_d;
    end
  end

endmodule

// File: rtl/memstrobe_gen.sv
module memstrobe_gen
  import memstrobe_pkg::*;
#(
  parameter int PHASES    = 16,
  parameter int ROW_TICKS = 5,
  parameter int ADDR_W    = 21,
  parameter int SEL_BIT   = 13,
  parameter int DIV       = 8,
  parameter int SYNC_ST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_idrom,
  input  logic              boot_ram,
  input  logic              refresh_req,
  input  logic              soft_reset,
  input  logic              ext_reset_n,
  input  logic              div_sel,
  output logic              ras_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              refresh_act,
  output logic              romsel_n,
  output logic              acc_start,
  output logic              busrst_n,
  output logic              clk_div
);

  localparam int PH_W = $clog2(PHASES);

  logic            rst_i_n;
  logic            bus_arst_n;
  logic [PH_W-1:0] ph_nxt;
  cyc_ctx_t        ctx_nxt;

  assign bus_arst_n = rst_n & ext_reset_n;

  ms_rst_sync #(.STAGES(SYNC_ST)) u_core_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .sclr    (1'b0),
    .rst_n_o (rst_i_n)
  );

  ms_rst_sync #(.STAGES(SYNC_ST)) u_bus_rst (
    .clk     (clk),
    .arst_n  (bus_arst_n),
    .sclr    (soft_reset),
    .rst_n_o (busrst_n)
  );

  ms_phase_seq #(
    .PHASES  (PHASES),
    .PH_W    (PH_W),
    .ADDR_W  (ADDR_W),
    .SEL_BIT (SEL_BIT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_idrom   (req_idrom),
    .boot_ram    (boot_ram),
    .refresh_req (refresh_req),
    .ph_nxt      (ph_nxt),
    .ctx_nxt     (ctx_nxt)
  );

  ms_strobe_dec #(
    .PHASES    (PHASES),
    .PH_W      (PH_W),
    .ROW_TICKS (ROW_TICKS)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ph_nxt      (ph_nxt),
    .ctx_nxt     (ctx_nxt),
    .ras_n       (ras_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .refresh_act (refresh_act),
    .romsel_n    (romsel_n),
    .acc_start   (acc_start)
  );

  ms_clk_div #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .div_sel (div_sel),
    .clk_div (clk_div)
  );

endmodule

// File: rtl/ms_strobe_chk.sv
module ms_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_reset_n,
  input logic div_sel,
  input logic ras_n,
  input logic oe_n,
  input logic we_n,
  input logic refresh_act,
  input logic romsel_n,
  input logic acc_start,
  input logic busrst_n,
  input logic clk_div
);

  logic pv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  // R4
  refr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_act |-> (oe_n && we_n && romsel_n));

  // R8 R9
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R3
  ras_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $fell(ras_n)) |-> (acc_start || refresh_act));

  // R2
  start_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> !ras_n);

  // R9
  we_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $fell(we_n)) |-> $past(!ras_n));

  // R11
  div_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !$past(div_sel)) |-> !clk_div);

  // R10
  busrst_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_reset_n |-> !busrst_n);

endmodule

bind memstrobe_gen ms_strobe_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_reset_n (ext_reset_n),
  .div_sel     (div_sel),
  .ras_n       (ras_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .refresh_act (refresh_act),
  .romsel_n    (romsel_n),
  .acc_start   (acc_start),
  .busrst_n    (busrst_n),
  .clk_div     (clk_div)
);

// File: tb/memstrobe_gen_test.sv
`timescale 1ns/1ps
module memstrobe_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_idrom, boot_ram, refresh_req;
  logic [20:0] req_addr;
  logic        soft_reset, ext_reset_n, div_sel;
  logic        ras_n, oe_n, we_n, refresh_act, romsel_n, acc_start, busrst_n, clk_div;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  memstrobe_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_idrom(req_idrom), .boot_ram(boot_ram),
    .refresh_req(refresh_req), .soft_reset(soft_reset), .ext_reset_n(ext_reset_n),
    .div_sel(div_sel), .ras_n(ras_n), .oe_n(oe_n), .we_n(we_n),
    .refresh_act(refresh_act), .romsel_n(romsel_n), .acc_start(acc_start),
    .busrst_n(busrst_n), .clk_div(clk_div)
  );

  // Behavioural reference state
  int m_s0 = 0, m_s1 = 0, m_ph = 0, m_kind = 0, m_cnt = 0;
  int m_wr = 0, m_a13 = 0, m_cs = 0, m_dram = 0;
  int m_b0 = 0, m_b1 = 0, m_div = 0;

  function automatic int in_rom_win(logic [20:0] a);
    return ((a >= 21'h000010 && a <= 21'h00FFFF) ||
            (a >= 21'h1F0000)) ? 1 : 0;
  endfunction

  task automatic chk(input logic got, input int exp, input string tag);
    checks++;
    if (got !== exp[0]) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %0d", tag, cyc, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    int ras_e, oe_e, we_e, ref_e, rom_e, st_e;
    cyc++;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_ph = 0; m_kind = 0; m_cnt = 0; m_div = 0;
      m_wr = 0; m_a13 = 0; m_cs = 0; m_dram = 0;
    end else begin
      if (m_s1 != 0) begin
        if (m_ph == 15) begin
          m_wr = 0; m_a13 = 0; m_cs = 0; m_dram = 0;
          if (refresh_req) m_kind = 1;
          else if (req_valid) begin
            m_kind = 2;
            m_wr   = req_write;
            m_a13  = req_addr[13];
            m_cs   = (!req_write && !boot_ram && in_rom_win(req_addr) != 0) ? 1 : 0;
            m_dram = (!req_write && m_cs == 0 && !req_idrom) ? 1 : 0;
          end else m_kind = 0;
        end
        m_ph  = (m_ph + 1) % 16;
        m_cnt = (m_cnt + 1) % 8;
        m_div = (div_sel && m_cnt >= 4) ? 1 : 0;
      end
      m_s1 = m_s0;
      m_s0 = 1;
    end
    if (!rst_n || !ext_reset_n || soft_reset) begin
      m_b0 = 0; m_b1 = 0;
    end else begin
      m_b1 = m_b0; m_b0 = 1;
    end
    ras_e = (m_kind != 0 && m_ph < 5) ? 0 : 1;
    ref_e = (m_kind == 1) ? 1 : 0;
    st_e  = (m_kind == 2 && m_ph == 0) ? 1 : 0;
    rom_e = (m_kind == 2) ? ((m_ph < 5) ? 1 - m_cs : m_a13) : 1;
    oe_e  = (m_kind == 2 && m_dram != 0 && m_ph >= 5) ? 0 : 1;
    we_e  = (m_kind == 2 && m_wr != 0 && m_ph >= 5 && m_ph <= 14) ? 0 : 1;
    #3;
    chk(ras_n, ras_e, "R3 ras_n");
    chk(refresh_act, ref_e, "R4 refresh_act");
    chk(acc_start, st_e, "R2 acc_start");
    chk(romsel_n, rom_e, (m_ph < 5) ? "R5 R6 romsel_n row" : "R7 romsel_n a13");
    chk(oe_n, oe_e, "R8 oe_n");
    chk(we_n, we_e, "R9 we_n");
    chk(busrst_n, m_b1, "R10 busrst_n");
    chk(clk_div, m_div, "R11 clk_div");
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: got running expected done", cyc);
      finish_run();
    end
  end

  // Hold an access request until it is accepted; optionally race a refresh
  task automatic do_acc(input logic [20:0] a, input logic wr, input logic idr,
                        input logic boot, input logic with_ref);
    @(negedge clk);
    req_addr = a; req_write = wr; req_idrom = idr; boot_ram = boot;
    req_valid = 1'b1;
    if (with_ref) refresh_req = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (refresh_act) refresh_req = 1'b0;
      if (acc_start) break;
    end
    req_valid = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic do_refresh();
    @(negedge clk);
    refresh_req = 1'b1;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (refresh_act) break;
    end
    refresh_req = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_idrom = 1'b0;
    boot_ram = 1'b0; refresh_req = 1'b0; req_addr = '0;
    soft_reset = 1'b0; ext_reset_n = 1'b1; div_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle levels held during reset
    chk(ras_n, 1, "R1 ras_n reset");
    chk(romsel_n, 1, "R1 romsel_n reset");
    chk(busrst_n, 0, "R1 busrst_n reset");
    chk(clk_div, 0, "R1 clk_div reset");
    rst_n = 1'b1;
    repeat (40) @(negedge clk);                       // R2 idle cycles, R11 running
    do_acc(21'h000010, 1'b0, 1'b0, 1'b0, 1'b0);      // R5 low window edge
    do_acc(21'h00FFFF, 1'b0, 1'b0, 1'b0, 1'b0);      // R5 high edge, a13=1 (R7)
    do_acc(21'h1F0000, 1'b0, 1'b0, 1'b0, 1'b0);      // R5 second window
    do_acc(21'h1FE000, 1'b0, 1'b0, 1'b0, 1'b0);      // R5 R7
    do_acc(21'h00000F, 1'b0, 1'b0, 1'b0, 1'b0);      // R6 below window, R8 DRAM read
    do_acc(21'h010000, 1'b0, 1'b0, 1'b0, 1'b0);      // R6 between windows
    do_acc(21'h002100, 1'b1, 1'b0, 1'b0, 1'b0);      // R6 write in window, R9
    do_acc(21'h002100, 1'b0, 1'b0, 1'b1, 1'b0);      // R6 boot mode 1, R8 DRAM read
    do_acc(21'h002000, 1'b0, 1'b1, 1'b1, 1'b0);      // R8 identification ROM read
    do_refresh();                                    // R4 refresh alone
    do_acc(21'h0A6000, 1'b1, 1'b0, 1'b0, 1'b1);      // R4 refresh wins, then write
    do_acc(21'h1F4000, 1'b0, 1'b0, 1'b0, 1'b1);      // R4 refresh wins, then ROM read
    @(negedge clk); soft_reset = 1'b1;               // R10 soft reset
    repeat (3) @(negedge clk); soft_reset = 1'b0;
    repeat (5) @(negedge clk); ext_reset_n = 1'b0;   // R10 external reset
    repeat (2) @(negedge clk); ext_reset_n = 1'b1;
    repeat (5) @(negedge clk); div_sel = 1'b0;       // R11 reserved setting
    do_acc(21'h003000, 1'b1, 1'b0, 1'b0, 1'b0);
    div_sel = 1'b1;
    repeat (30) @(negedge clk);
    finish_run();
  end

endmodule